// File: doc/BRIEF.md
# Ingress VLAN Forwarding Filter

The block sits after the address lookup stage of a switch. For each frame it takes the candidate egress port mask and applies the ingress port's policy. The policy has four parts: the acceptable frame type, an optional VLAN membership check with three strictness levels, a per-port reachability row, and removal of the ingress port itself. The result is either a final egress port mask or a drop with a reason code. It also reports the VID that was resolved for the frame and the per-port egress tag bits taken from the matching VLAN entry.

Per-port configuration comes in as flat vectors indexed by port number. A small associative VLAN table holds, for each entry, a valid bit, a VID, a member bitmap and an egress tag bitmap. The table is loaded through a one-entry-per-cycle write port. Frames enter and results leave through valid/ready handshakes, with one register stage in between.

Top module: `vlan_ingress_filter`

## Requirements
- R1: The frame type filter is selected per port by the 2-bit field `cfg_acc_i[2p+1:2p]`. Code 1 drops untagged frames with reason 1. Code 2 drops tagged frames with reason 2. Codes 0 and 3 accept both kinds.
- R2: The untagged-frame drop of R1 also applies when the port is in matrix mode (mode code 0).
- R3: Mode code 0 in `cfg_vmode_i[2p+1:2p]` skips the VLAN table. A missing VID or a missing membership bit never drops the frame, and `out_egtag_o` is zero.
- R4: The resolved VID is the frame's VID when `in_tagged_i` is 1. Otherwise it is the ingress port's default VID `cfg_pvid_i[p*VID_W +: VID_W]`. It is reported on `out_vid_o` and used for the table lookup.
- R5: When no valid table entry matches the VID, the frame is dropped with reason 3 in mode 3 (strict) and mode 2 (check). It is not dropped in mode 1 (fallback).
- R6: When the entry's member bitmap lacks the ingress port, the frame is dropped with reason 4 only in mode 3. Modes 1 and 2 forward it.
- R7: The final mask is the candidate mask AND row p of `cfg_matrix_i` (bits `[p*NUM_PORTS +: NUM_PORTS]`), with bit p cleared. Example: candidate 0x5F, row 0x43, port 0 gives 0x42.
- R8: If a frame passes every other check but its final mask is zero, it is dropped with reason 5.
- R9: A dropped result has `out_drop_o`=1, `out_mask_o`=0 and `out_egtag_o`=0. A forwarded result has `out_drop_o`=0 and reason 0. When several drop causes apply, the lowest-numbered reason is reported.
- R10: For a forwarded frame that hit the table in modes 1 to 3, `out_egtag_o` is the entry's egress tag bitmap AND the final mask. On a table miss it is zero.
- R11: After reset `out_valid_o` is 0. A frame accepted when `in_valid_i` and `in_ready_o` are both high gives its result on the next cycle. The result is held unchanged while `out_ready_i` is low. `in_ready_o` is high exactly when the output register is empty or being read.
- R12: A table write is used by lookups from the next cycle on. When several valid entries match, the lowest index wins. Reset clears every valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Frame descriptor valid |
| in_ready_o | output | 1 | Descriptor can be accepted |
| in_port_i | input | PORT_W | Ingress port number |
| in_tagged_i | input | 1 | Frame carries a VLAN tag |
| in_vid_i | input | VID_W | VID from the tag |
| in_cand_i | input | NUM_PORTS | Candidate egress mask from address lookup |
| cfg_acc_i | input | 2*NUM_PORTS | Per-port acceptable frame type |
| cfg_vmode_i | input | 2*NUM_PORTS | Per-port VLAN check mode |
| cfg_pvid_i | input | VID_W*NUM_PORTS | Per-port default VID |
| cfg_matrix_i | input | NUM_PORTS*NUM_PORTS | Per-port reachability rows |
| vt_we_i | input | 1 | VLAN table write strobe |
| vt_idx_i | input | VT_IDX_W | Entry index to write |
| vt_valid_i | input | 1 | Valid bit to write |
| vt_vid_i | input | VID_W | VID to write |
| vt_member_i | input | NUM_PORTS | Member bitmap to write |
| vt_egtag_i | input | NUM_PORTS | Egress tag bitmap to write |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result consumed |
| out_mask_o | output | NUM_PORTS | Final egress mask |
| out_drop_o | output | 1 | Frame dropped |
| out_reason_o | output | 3 | Drop reason code |
| out_vid_o | output | VID_W | Resolved VID |
| out_egtag_o | output | NUM_PORTS | Egress tag bits for the forwarded ports |

## Verification
Each result field appears exactly one cycle after its descriptor is accepted. Table writes change the lookup one cycle after the write edge. The bench drives inputs on the falling edge and advances its behavioural model at the rising edge. It compares every output on the next falling edge, so each check samples the cycle in which the register stage has just loaded. During backpressure the model keeps its pending result, and the same held values are checked on each stalled cycle.

// File: rtl/vlan_filt_pkg.sv
package vlan_filt_pkg;

  typedef enum logic [1:0] {
    ACC_ANY      = 2'd0,
    ACC_TAG_ONLY = 2'd1,
    ACC_UNT_ONLY = 2'd2,
    ACC_ANY_ALT  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    VM_MATRIX   = 2'd0,
    VM_FALLBACK = 2'd1,
    VM_CHECK    = 2'd2,
    VM_STRICT   = 2'd3
  } vmode_e;

  typedef enum logic [2:0] {
    RSN_NONE     = 3'd0,
    RSN_UNTAGGED = 3'd1,
    RSN_TAGGED   = 3'd2,
    RSN_VID_MISS = 3'd3,
    RSN_NOT_MEM  = 3'd4,
    RSN_EMPTY    = 3'd5
  } reason_e;

endpackage

// File: rtl/vlan_table.sv
module vlan_table #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned VID_W     = 12,
  parameter int unsigned VT_DEPTH  = 8,
  localparam int unsigned VT_IDX_W = $clog2(VT_DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [VT_IDX_W-1:0]  idx_i,
  input  logic                 valid_i,
  input  logic [VID_W-1:0]     vid_i,
  input  logic [NUM_PORTS-1:0] member_i,
  input  logic [NUM_PORTS-1:0] egtag_i,
  input  logic [VID_W-1:0]     lk_vid_i,
  output logic                 hit_o,
  output logic [NUM_PORTS-1:0] member_o,
  output logic [NUM_PORTS-1:0] egtag_o
);

  logic [VT_DEPTH-1:0]                match;
  logic [VT_DEPTH-1:0][NUM_PORTS-1:0] ent_mem;
  logic [VT_DEPTH-1:0][NUM_PORTS-1:0] ent_eg;

  for (genvar g = 0; g < VT_DEPTH; g++) begin : gen_ent
    logic                 v_q;
    logic [VID_W-1:0]     vid_q;
    logic [NUM_PORTS-1:0] mem_q;
    logic [NUM_PORTS-1:0] eg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q   <= 1'b0;
        vid_q <= '0;
        mem_q <= '0;
        eg_q  <= '0;
      end else if (we_i && idx_i == VT_IDX_W'(g)) begin
        v_q   <= valid_i;
        vid_q <= vid_i;
        mem_q <= member_i;
        eg_q  <= egtag_i;
      end
    end

    assign match[g]   = v_q && (vid_q == lk_vid_i);
    assign ent_mem[g] = mem_q;
    assign ent_eg[g]  = eg_q;
  end

  // lowest matching index wins
  always_comb begin
    hit_o    = 1'b0;
    member_o = '0;
    egtag_o  = '0;
    for (int i = VT_DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o    = 1'b1;
        member_o = ent_mem[i];
        egtag_o  = ent_eg[i];
      end
    end
  end

endmodule

// File: rtl/vlan_policy.sv
module vlan_policy
  import vlan_filt_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic [PORT_W-1:0]    port_i,
  input  logic                 tagged_i,
  input  logic [NUM_PORTS-1:0] cand_i,
  input  logic [1:0]           acc_i,
  input  logic [1:0]           vmode_i,
  input  logic [NUM_PORTS-1:0] row_i,
  input  logic                 hit_i,
  input  logic [NUM_PORTS-1:0] member_i,
  input  logic [NUM_PORTS-1:0] egtag_i,
  output logic [NUM_PORTS-1:0] mask_o,
  output logic                 drop_o,
  output reason_e              reason_o,
  output logic [NUM_PORTS-1:0] egtag_o
);

  acc_e                 acc;
  vmode_e               vmode;
  logic [NUM_PORTS-1:0] self_bit;
  logic [NUM_PORTS-1:0] raw_mask;
  logic                 use_table;

  assign acc       = acc_e'(acc_i);
  assign vmode     = vmode_e'(vmode_i);
  assign self_bit  = {{(NUM_PORTS-1){1'b0}}, 1'b1} << port_i;
  assign raw_mask  = cand_i & row_i & ~self_bit;
  assign use_table = (vmode != VM_MATRIX);

  // ordered checks: frame type precedes the matrix bypass
  always_comb begin
    reason_o = RSN_NONE;
    if (!tagged_i && acc == ACC_TAG_ONLY)
      reason_o = RSN_UNTAGGED;
    else if (tagged_i && acc == ACC_UNT_ONLY)
      reason_o = RSN_TAGGED;
    else if (use_table && !hit_i && vmode != VM_FALLBACK)
      reason_o = RSN_VID_MISS;
    else if (vmode == VM_STRICT && hit_i && !member_i[port_i])
      reason_o = RSN_NOT_MEM;
    else if (raw_mask == '0)
      reason_o = RSN_EMPTY;
  end

  assign drop_o  = (reason_o != RSN_NONE);
  assign mask_o  = drop_o ? '0 : raw_mask;
  assign egtag_o = (drop_o || !use_table || !hit_i) ? '0 : (egtag_i & raw_mask);

endmodule

// File: rtl/vlan_ingress_filter.sv
module vlan_ingress_filter
  import vlan_filt_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned VID_W     = 12,
  parameter int unsigned VT_DEPTH  = 8,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS),
  localparam int unsigned VT_IDX_W = $clog2(VT_DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           in_valid_i,
  output logic                           in_ready_o,
  input  logic [PORT_W-1:0]              in_port_i,
  input  logic                           in_tagged_i,
  input  logic [VID_W-1:0]               in_vid_i,
  input  logic [NUM_PORTS-1:0]           in_cand_i,
  input  logic [2*NUM_PORTS-1:0]         cfg_acc_i,
  input  logic [2*NUM_PORTS-1:0]         cfg_vmode_i,
  input  logic [VID_W*NUM_PORTS-1:0]     cfg_pvid_i,
  input  logic [NUM_PORTS*NUM_PORTS-1:0] cfg_matrix_i,
  input  logic                           vt_we_i,
  input  logic [VT_IDX_W-1:0]            vt_idx_i,
  input  logic                           vt_valid_i,
  input  logic [VID_W-1:0]               vt_vid_i,
  input  logic [NUM_PORTS-1:0]           vt_member_i,
  input  logic [NUM_PORTS-1:0]           vt_egtag_i,
  output logic                           out_valid_o,
  input  logic                           out_ready_i,
  output logic [NUM_PORTS-1:0]           out_mask_o,
  output logic                           out_drop_o,
  output logic [2:0]                     out_reason_o,
  output logic [VID_W-1:0]               out_vid_o,
  output logic [NUM_PORTS-1:0]           out_egtag_o
);

  logic [1:0]           sel_acc;
  logic [1:0]           sel_vmode;
  logic [VID_W-1:0]     sel_pvid;
  logic [NUM_PORTS-1:0] sel_row;
  logic [VID_W-1:0]     res_vid;

  logic                 vt_hit;
  logic [NUM_PORTS-1:0] vt_mem;
  logic [NUM_PORTS-1:0] vt_eg;

  logic [NUM_PORTS-1:0] pol_mask;
  logic                 pol_drop;
  reason_e              pol_reason;
  logic [NUM_PORTS-1:0] pol_eg;
  logic                 accept;

  assign sel_acc   = cfg_acc_i[in_port_i*2 +: 2];
  assign sel_vmode = cfg_vmode_i[in_port_i*2 +: 2];
  assign sel_pvid  = cfg_pvid_i[in_port_i*VID_W +: VID_W];
  assign sel_row   = cfg_matrix_i[in_port_i*NUM_PORTS +: NUM_PORTS];
  assign res_vid   = in_tagged_i ? in_vid_i : sel_pvid;

  vlan_table #(
    .NUM_PORTS(NUM_PORTS),
    .VID_W    (VID_W),
    .VT_DEPTH (VT_DEPTH)
  ) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (vt_we_i),
    .idx_i   (vt_idx_i),
    .valid_i (vt_valid_i),
    .vid_i   (vt_vid_i),
    .member_i(vt_member_i),
    .egtag_i (vt_egtag_i),
    .lk_vid_i(res_vid),
    .hit_o   (vt_hit),
    .member_o(vt_mem),
    .egtag_o (vt_eg)
  );

  vlan_policy #(
    .NUM_PORTS(NUM_PORTS)
  ) u_policy (
    .port_i  (in_port_i),
    .tagged_i(in_tagged_i),
    .cand_i  (in_cand_i),
    .acc_i   (sel_acc),
    .vmode_i (sel_vmode),
    .row_i   (sel_row),
    .hit_i   (vt_hit),
    .member_i(vt_mem),
    .egtag_i (vt_eg),
    .mask_o  (pol_mask),
    .drop_o  (pol_drop),
    .reason_o(pol_reason),
    .egtag_o (pol_eg)
  );

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_mask_o   <= '0;
      out_drop_o   <= 1'b0;
      out_reason_o <= '0;
      out_vid_o    <= '0;
      out_egtag_o  <= '0;
    end else if (accept) begin
      out_valid_o  <= 1'b1;
      out_mask_o   <= pol_mask;
      out_drop_o   <= pol_drop;
      out_reason_o <= pol_reason;
      out_vid_o    <= res_vid;
      out_egtag_o  <= pol_eg;
    end else if (out_ready_i) begin
      out_valid_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/vlan_filt_chk.sv
module vlan_filt_chk #(
  parameter int unsigned NUM_PORTS = 8,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           in_valid_i,
  input logic                           in_ready_o,
  input logic [PORT_W-1:0]              in_port_i,
  input logic                           in_tagged_i,
  input logic [NUM_PORTS-1:0]           in_cand_i,
  input logic [2*NUM_PORTS-1:0]         cfg_acc_i,
  input logic [NUM_PORTS*NUM_PORTS-1:0] cfg_matrix_i,
  input logic                           out_valid_o,
  input logic                           out_ready_i,
  input logic [NUM_PORTS-1:0]           out_mask_o,
  input logic                           out_drop_o,
  input logic [2:0]                     out_reason_o,
  input logic [NUM_PORTS-1:0]           out_egtag_o
);

  logic [PORT_W-1:0]    cap_port;
  logic [NUM_PORTS-1:0] cap_allow;
  logic [1:0]           cap_acc;
  logic                 cap_tagged;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_port   <= '0;
      cap_allow  <= '0;
      cap_acc    <= '0;
      cap_tagged <= 1'b0;
    end else if (in_valid_i && in_ready_o) begin
      cap_port   <= in_port_i;
      cap_allow  <= in_cand_i & cfg_matrix_i[in_port_i*NUM_PORTS +: NUM_PORTS];
      cap_acc    <= cfg_acc_i[in_port_i*2 +: 2];
      cap_tagged <= in_tagged_i;
    end
  end

  AST_NO_INGRESS_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !out_mask_o[cap_port]);                                    // R7
  AST_MASK_WITHIN_ALLOWED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_mask_o & ~cap_allow) == '0));                        // R7
  AST_DROP_CLEARS_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_drop_o) |-> (out_mask_o == '0 && out_egtag_o == '0));  // R9
  AST_UNTAGGED_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && cap_acc == 2'd1 && !cap_tagged) |-> (out_drop_o && out_reason_o == 3'd1)); // R2
  AST_FORWARD_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_drop_o) |-> (out_mask_o != '0));                      // R8
  AST_ONE_CYCLE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);                               // R11
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_mask_o) && $stable(out_reason_o))); // R11

endmodule

bind vlan_ingress_filter vlan_filt_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_port_i   (in_port_i),
  .in_tagged_i (in_tagged_i),
  .in_cand_i   (in_cand_i),
  .cfg_acc_i   (cfg_acc_i),
  .cfg_matrix_i(cfg_matrix_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_mask_o  (out_mask_o),
  .out_drop_o  (out_drop_o),
  .out_reason_o(out_reason_o),
  .out_egtag_o (out_egtag_o)
);

// File: tb/sim_vlan_ingress_filter.sv
`timescale 1ns/1ps
module sim_vlan_ingress_filter;
  localparam int NP = 8;
  localparam int VW = 12;
  localparam int VD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             in_valid = 0, in_tagged = 0, out_ready = 1;
  logic [2:0]       in_port = 0;
  logic [VW-1:0]    in_vid = 0;
  logic [NP-1:0]    in_cand = 0;
  logic [2*NP-1:0]  cfg_acc, cfg_vmode;
  logic [VW*NP-1:0] cfg_pvid;
  logic [NP*NP-1:0] cfg_matrix;
  logic             vt_we = 0, vt_valid = 0;
  logic [2:0]       vt_idx = 0;
  logic [VW-1:0]    vt_vid = 0;
  logic [NP-1:0]    vt_member = 0, vt_egtag = 0;
  logic             in_ready, out_valid, out_drop;
  logic [NP-1:0]    out_mask, out_egtag;
  logic [2:0]       out_reason;
  logic [VW-1:0]    out_vid;

  int m_acc [NP];
  int m_vm  [NP];
  int m_pvid[NP];
  int m_row [NP];
  bit t_v   [VD];
  int t_vid [VD];
  int t_mem [VD];
  int t_eg  [VD];

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      cfg_acc[p*2 +: 2]     = 2'(m_acc[p]);
      cfg_vmode[p*2 +: 2]   = 2'(m_vm[p]);
      cfg_pvid[p*VW +: VW]  = VW'(m_pvid[p]);
      cfg_matrix[p*NP +: NP] = NP'(m_row[p]);
    end
  end

  vlan_ingress_filter #(.NUM_PORTS(NP), .VID_W(VW), .VT_DEPTH(VD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_port_i(in_port), .in_tagged_i(in_tagged), .in_vid_i(in_vid), .in_cand_i(in_cand),
    .cfg_acc_i(cfg_acc), .cfg_vmode_i(cfg_vmode), .cfg_pvid_i(cfg_pvid),
    .cfg_matrix_i(cfg_matrix), .vt_we_i(vt_we), .vt_idx_i(vt_idx), .vt_valid_i(vt_valid),
    .vt_vid_i(vt_vid), .vt_member_i(vt_member), .vt_egtag_i(vt_egtag),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_mask_o(out_mask),
    .out_drop_o(out_drop), .out_reason_o(out_reason), .out_vid_o(out_vid),
    .out_egtag_o(out_egtag));

  int checks = 0, errors = 0;
  bit done = 0;
  bit mv = 0;
  int e_mask = 0, e_drop = 0, e_rsn = 0, e_vid = 0, e_eg = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural expectation for the current inputs
  task automatic predict(output int mask, output int drop, output int rsn,
                         output int vid, output int eg);
    int p = int'(in_port);
    bit hit = 0;
    int mem = 0, teg = 0, raw;
    vid = in_tagged ? int'(in_vid) : m_pvid[p];
    for (int i = 0; i < VD; i++)
      if (!hit && t_v[i] && t_vid[i] == vid) begin hit = 1; mem = t_mem[i]; teg = t_eg[i]; end
    raw = int'(in_cand) & m_row[p] & ~(1 << p) & 'hFF;
    rsn = 0;
    if (!in_tagged && m_acc[p] == 1) rsn = 1;
    else if (in_tagged && m_acc[p] == 2) rsn = 2;
    else if (m_vm[p] != 0) begin
      if (!hit && m_vm[p] != 1) rsn = 3;
      else if (hit && m_vm[p] == 3 && !mem[p]) rsn = 4;
    end
    if (rsn == 0 && raw == 0) rsn = 5;
    drop = (rsn != 0);
    mask = drop ? 0 : raw;
    eg   = (drop || m_vm[p] == 0 || !hit) ? 0 : (teg & raw);
  endtask

  task automatic cycle(string req);
    int nm, nd, nr, nv, ne;
    bit acc = in_valid && (!mv || out_ready);
    predict(nm, nd, nr, nv, ne);
    @(posedge clk);
    if (acc) begin
      mv = 1; e_mask = nm; e_drop = nd; e_rsn = nr; e_vid = nv; e_eg = ne;
    end else if (out_ready) mv = 0;
    if (vt_we) begin
      t_v[vt_idx] = vt_valid; t_vid[vt_idx] = int'(vt_vid);
      t_mem[vt_idx] = int'(vt_member); t_eg[vt_idx] = int'(vt_egtag);
    end
    @(negedge clk);
    chk(req, "out_valid", int'(out_valid), int'(mv));
    chk(req, "in_ready", int'(in_ready), int'(!mv || out_ready));
    if (mv) begin
      chk(req, "mask", int'(out_mask), e_mask);
      chk(req, "drop", int'(out_drop), e_drop);
      chk(req, "reason", int'(out_reason), e_rsn);
      chk(req, "vid", int'(out_vid), e_vid);
      chk(req, "egtag", int'(out_egtag), e_eg);
    end
  endtask

  task automatic send(string req, int p, bit tg, int vid, int cand);
    in_valid = 1; in_port = 3'(p); in_tagged = tg; in_vid = VW'(vid); in_cand = NP'(cand);
    cycle(req);
    in_valid = 0;
  endtask

  task automatic vt_wr(int idx, bit v, int vid, int mem, int eg);
    vt_we = 1; vt_idx = 3'(idx); vt_valid = v; vt_vid = VW'(vid);
    vt_member = NP'(mem); vt_egtag = NP'(eg);
    cycle("R12");
    vt_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin m_acc[p] = 0; m_vm[p] = 3; m_pvid[p] = 0; m_row[p] = 'hFF; end
    for (int i = 0; i < VD; i++) begin t_v[i] = 0; t_vid[i] = 0; t_mem[i] = 0; t_eg[i] = 0; end
    m_row[0] = 'h43;
    repeat (2) @(negedge clk);
    rst_n = 1;
    cycle("R11");                                 // reset state
    vt_wr(0, 1, 0,  'h5F, 'h03);
    vt_wr(1, 1, 20, 'hF0, 'hFF);
    vt_wr(2, 1, 10, 'hFF, 'h0F);
    vt_wr(3, 1, 10, 'h00, 'h00);
    send("R7", 0, 0, 0, 'h5F);                    // 0x42, egtag 0x02
    send("R10", 0, 0, 0, 'hFF);
    send("R4", 0, 1, 10, 'hFF);                   // idx2 wins over idx3
    send("R12", 0, 1, 10, 'h02);
    m_acc[0] = 1;
    send("R1", 0, 0, 0, 'hFF);
    send("R1", 0, 1, 10, 'hFF);
    m_acc[0] = 2;
    send("R1", 0, 1, 10, 'hFF);
    send("R4", 0, 0, 0, 'hFF);
    m_acc[0] = 0;
    m_acc[1] = 1; m_vm[1] = 0;
    send("R2", 1, 0, 0, 'hFF);
    m_acc[1] = 0;
    send("R3", 1, 1, 99, 'hFF);
    send("R3", 1, 1, 20, 'hFF);
    send("R3", 1, 0, 0, 'hFF);
    m_pvid[2] = 5;
    send("R4", 2, 0, 0, 'hFF);                    // pvid 5 misses under strict
    foreach (m_vm[q]) if (q == 2) m_vm[q] = 3;
    send("R5", 2, 1, 99, 'hFF);
    m_vm[2] = 2; send("R5", 2, 1, 99, 'hFF);
    m_vm[2] = 1; send("R5", 2, 1, 99, 'hFF);
    m_vm[0] = 3; send("R6", 0, 1, 20, 'hFF);
    m_vm[0] = 2; send("R6", 0, 1, 20, 'hFF);
    m_vm[0] = 1; send("R6", 0, 1, 20, 'hFF);
    m_vm[0] = 3;
    send("R8", 0, 0, 0, 'h01);
    send("R9", 0, 0, 0, 'h3C);
    // backpressure
    out_ready = 0;
    send("R11", 0, 0, 0, 'h5F);
    in_valid = 1; in_port = 3; in_tagged = 1; in_vid = 10; in_cand = 'hF0;
    cycle("R11"); cycle("R11");
    out_ready = 1;
    cycle("R11");
    in_valid = 0;
    cycle("R11");
    // table rewrites
    m_vm[2] = 3;
    vt_wr(4, 1, 99, 'hFF, 'h00);
    send("R12", 2, 1, 99, 'hFF);
    vt_wr(2, 0, 10, 'hFF, 'h0F);
    send("R12", 0, 1, 10, 'hFF);                  // idx3 now hits, port0 absent
    // mixed traffic
    for (int p = 0; p < NP; p++) begin
      m_acc[p] = $urandom_range(0, 3); m_vm[p] = $urandom_range(0, 3);
      m_pvid[p] = (p % 2 == 0) ? 0 : 20;
    end
    for (int k = 0; k < 400; k++) begin
      int vids[5] = '{0, 10, 20, 99, 5};
      in_valid = 1'($urandom_range(0, 1)); out_ready = 1'($urandom_range(0, 3) != 0);
      in_port = 3'($urandom_range(0, 7)); in_tagged = 1'($urandom_range(0, 1));
      in_vid = VW'(vids[$urandom_range(0, 4)]); in_cand = NP'($urandom_range(0, 255));
      cycle("R7");
    end
    in_valid = 0; out_ready = 1;
    cycle("R11");
    // reset empties table
    rst_n = 0;
    @(negedge clk);
    for (int i = 0; i < VD; i++) t_v[i] = 0;
    mv = 0;
    rst_n = 1;
    for (int p = 0; p < NP; p++) begin m_acc[p] = 0; m_vm[p] = 3; end
    cycle("R11");
    send("R12", 0, 0, 0, 'hFF);                   // vid 0 gone -> reason 3
    cycle("R12");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule